// File: doc/BRIEF.md
# Interleaved Four-Bank Block Refill Engine

This block sits on the memory side of a cache and serves block refills. A block of four 32-bit words is spread over four banks, so that word i of a block lives in bank i. Once a read request is accepted, the row address goes to all four banks in a single cycle. The banks then run their access concurrently. When the access delay has elapsed, the four words leave over a one-word-wide return path, one word per cycle and in bank order. A full block costs 1 + 15 + 4 = 20 cycles, where a single-bank, word-at-a-time organisation would need 65.

The same request port also takes single-word writes, which the block uses to fill the banks. A write starts only the bank named by the two low word-address bits. That bank finishes after its own access delay, and a write has no return phase. The engine handles one operation at a time. Its ready output drops from acceptance until the operation ends.

Top module: `bank_refill_engine`

## Requirements
- R1: While reset is asserted and directly after it, req_ready_o is 1, rd_valid_o is 0 and done_o is 0.
- R2: A request is taken only in a cycle where req_valid_i and req_ready_o are both 1. req_ready_o is 0 from the following cycle until the operation finishes, and it returns to 1 in the first cycle after the operation. A request held high across that point is accepted in that first ready cycle.
- R3: Take the cycle in which a read is accepted as cycle 0. rd_valid_o is 0 in cycles 1 to 15 and 1 in cycles 16 to 19, and no word arrives earlier.
- R4: The words of a read come out in bank order. In cycle 16+i, rd_bank_o equals i and rd_data_o holds the word stored at word address {row, i}, where row is req_addr_i[5:2].
- R5: For a read, req_addr_i[1:0] is ignored, and the whole block of the row is returned starting at bank 0.
- R6: done_o is 1 for exactly one cycle per read: the cycle of the bank-3 word.
- R7: A write with wdata W to word address A stores W in bank A[1:0] at row A[5:2]. rd_valid_o stays 0 during a write. done_o pulses once, in cycle 15 after acceptance, and req_ready_o is 1 again in cycle 16.
- R8: A write changes only its target word. Every other stored word reads back unchanged.
- R9: A request presented while req_ready_o is 0 has no effect, either on the data being returned or on the stored contents.
- R10: All banks started by a read complete their access in the same cycle. A write completes in exactly one bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Engine idle; the request is taken this cycle |
| req_write_i | input | 1 | 1: single-word write, 0: block read |
| req_addr_i | input | ADDR_W (6) | Word address; bits [1:0] select the bank, the upper bits select the row |
| req_wdata_i | input | DATA_W (32) | Write data |
| rd_valid_o | output | 1 | Return word valid |
| rd_bank_o | output | 2 | Bank (word position in the block) of the return word |
| rd_data_o | output | DATA_W (32) | Return word, zero when not valid |
| done_o | output | 1 | Operation complete (last read word, or write commit) |

## Verification
Two events can fall in the same cycle. The first is the final return word of a read paired with the done pulse. The second is the end of one operation paired with a queued request that is already waiting. The bench provokes the first on every block read and checks done_o cycle by cycle against the computed bank index. It provokes the second by raising the next read request during the last word and holding it. Acceptance must then happen on the first ready cycle, which the bench confirms by timing the chained read's first word 16 cycles after that cycle. A further request is injected in the middle of a busy read. Afterwards, both the stream in progress and a full readback must match the bench's model memory.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_STREAM = 2'd2
  } refill_state_e;
endpackage

// File: rtl/refill_bank.sv
module refill_bank #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 4,
  parameter int LAT    = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ROW_W;
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              busy_q, we_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ROW_W-1:0]  row_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  assign ack_o   = busy_q && (cnt_q == '0);
  assign rdata_o = rdata_q;

  // access delay: ack in the LAT-th cycle after start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      cnt_q   <= '0;
      row_q   <= '0;
      wdata_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      we_q    <= we_i;
      cnt_q   <= CNT_W'(LAT - 1);
      row_q   <= row_i;
      wdata_q <= wdata_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ack_o && we_q)  mem_q[row_q] <= wdata_q;
    if (ack_o && !we_q) rdata_q      <= mem_q[row_q];
  end
endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [SEL_W-1:0] req_sel_i,
  input  logic [NBANK-1:0] bank_ack_i,
  output logic             req_ready_o,
  output logic [NBANK-1:0] bank_start_o,
  output logic             bank_we_o,
  output logic             op_read_o,
  output logic             rd_valid_o,
  output logic [SEL_W-1:0] beat_o,
  output logic             done_o
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NBANK - 1);

  refill_state_e    state_q;
  logic             write_q;
  logic [SEL_W-1:0] beat_q;
  logic             accept, any_ack;

  assign accept  = req_valid_i && (state_q == ST_IDLE);
  assign any_ack = |bank_ack_i;

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      bank_start_o[b] = accept && (!req_write_i || (req_sel_i == SEL_W'(b)));
    end
  end

  assign bank_we_o   = req_write_i;
  assign op_read_o   = !write_q;
  assign req_ready_o = (state_q == ST_IDLE);
  assign rd_valid_o  = (state_q == ST_STREAM);
  assign beat_o      = beat_q;
  assign done_o      = ((state_q == ST_STREAM) && (beat_q == LAST)) ||
                       ((state_q == ST_ACCESS) && any_ack && write_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_ACCESS;
          write_q <= req_write_i;
        end
        ST_ACCESS: if (any_ack) begin
          state_q <= write_q ? ST_IDLE : ST_STREAM;
          beat_q  <= '0;
        end
        ST_STREAM: begin
          if (beat_q == LAST) state_q <= ST_IDLE;
          else                beat_q  <= beat_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/refill_return_mux.sv
module refill_return_mux #(
  parameter int NBANK  = 4,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 2
) (
  input  logic [NBANK-1:0][DATA_W-1:0] bank_data_i,
  input  logic [SEL_W-1:0]             sel_i,
  input  logic                         valid_i,
  output logic [DATA_W-1:0]            data_o
);
  assign data_o = valid_i ? bank_data_i[sel_i] : '0;
endmodule

// File: rtl/bank_refill_engine.sv
module bank_refill_engine #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 6,
  parameter int NBANK      = 4,
  parameter int ACCESS_LAT = 15
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic                     req_write_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  output logic                     rd_valid_o,
  output logic [$clog2(NBANK)-1:0] rd_bank_o,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     done_o
);
  localparam int SEL_W = $clog2(NBANK);
  localparam int ROW_W = ADDR_W - SEL_W;

  logic [NBANK-1:0]             bank_start, bank_ack;
  logic [NBANK-1:0][DATA_W-1:0] bank_rdata;
  logic                         bank_we, op_read;
  logic [SEL_W-1:0]             beat;

  refill_ctrl #(.NBANK(NBANK), .SEL_W(SEL_W)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_sel_i    (req_addr_i[SEL_W-1:0]),
    .bank_ack_i   (bank_ack),
    .req_ready_o  (req_ready_o),
    .bank_start_o (bank_start),
    .bank_we_o    (bank_we),
    .op_read_o    (op_read),
    .rd_valid_o   (rd_valid_o),
    .beat_o       (beat),
    .done_o       (done_o)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    refill_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W), .LAT(ACCESS_LAT)) i_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (bank_start[b]),
      .we_i    (bank_we),
      .row_i   (req_addr_i[ADDR_W-1:SEL_W]),
      .wdata_i (req_wdata_i),
      .ack_o   (bank_ack[b]),
      .rdata_o (bank_rdata[b])
    );
  end

  refill_return_mux #(.NBANK(NBANK), .DATA_W(DATA_W), .SEL_W(SEL_W)) i_mux (
    .bank_data_i (bank_rdata),
    .sel_i       (beat),
    .valid_i     (rd_valid_o),
    .data_o      (rd_data_o)
  );

  assign rd_bank_o = beat;
endmodule

// File: rtl/refill_checker.sv
module refill_checker #(
  parameter int NBANK = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_valid_i,
  input logic                     req_ready_o,
  input logic                     rd_valid_o,
  input logic [$clog2(NBANK)-1:0] rd_bank_o,
  input logic                     done_o,
  input logic [NBANK-1:0]         bank_ack,
  input logic                     op_read
);
  localparam int SEL_W = $clog2(NBANK);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NBANK - 1);

  p_ready_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  p_busy_stream_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !req_ready_o);

  p_first_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> rd_bank_o == '0);

  p_bank_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && rd_bank_o != LAST |=>
      rd_valid_o && rd_bank_o == SEL_W'($past(rd_bank_o) + 1'b1));

  p_done_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && rd_bank_o == LAST |-> done_o);

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_bank_sync_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bank_ack) && op_read |-> (&bank_ack));

  p_write_one_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bank_ack) && !op_read |-> $countones(bank_ack) == 1);
endmodule

bind bank_refill_engine refill_checker #(.NBANK(NBANK)) i_refill_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rd_valid_o  (rd_valid_o),
  .rd_bank_o   (rd_bank_o),
  .done_o      (done_o),
  .bank_ack    (bank_ack),
  .op_read     (op_read)
);

// File: tb/test_bank_refill_engine.sv
module test_bank_refill_engine;
  localparam int NWORD = 64;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rd_valid, done;
  logic [1:0]  rd_bank;
  logic [31:0] rd_data;

  logic [31:0] exp_mem [NWORD];
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bank_refill_engine i_bank_refill_engine (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .rd_valid_o  (rd_valid),
    .rd_bank_o   (rd_bank),
    .rd_data_o   (rd_data),
    .done_o      (done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pattern(input int a, input int salt);
    return {8'h5A ^ 8'(salt), 8'(a), 8'(~a), 8'(a * 3 + salt)};
  endfunction

  // write: done in cycle 15, ready back in cycle 16
  task automatic do_write(input int a, input logic [31:0] d);
    bit ok = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready before write", req_ready, 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    for (int k = 1; k <= 15; k++) begin
      if (k > 1) @(negedge clk);
      if (rd_valid || req_ready || (done != (k == 15))) ok = 1'b0;
    end
    @(negedge clk);
    check(ok && req_ready, "R7 write timing", {rd_valid, done, req_ready}, 3'b001);
    exp_mem[a] = d;
  endtask

  // read: cycle 0 = acceptance; words in cycles 16..19 (R3, R4, R6)
  task automatic do_read(input int a, input bit chained, input bit poke_busy,
                         input bit hold_next, input int next_a);
    int row = a >> 2;
    if (!chained) begin
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 6'(a);
    end
    check(req_ready == 1'b1, "R2 ready at accept", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= 19; k++) begin
      if (k > 1) @(negedge clk);
      if (poke_busy && k == 5) begin  // R9 request while busy
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = 6'(a ^ 1); req_wdata = 32'hDEAD_BEEF;
      end
      if (poke_busy && k == 19) begin
        req_valid = 1'b0; req_write = 1'b0;
      end
      if (hold_next && k == 19) begin  // R2 queued request
        req_valid = 1'b1; req_write = 1'b0; req_addr = 6'(next_a);
      end
      if (k < 16) begin
        check(!rd_valid && !done && !req_ready, "R3 quiet during access",
              {rd_valid, done, req_ready}, 0);
      end else begin
        check(rd_valid, "R3 word valid", rd_valid, 1);
        check(rd_bank == 2'(k - 16), "R4 bank order", rd_bank, k - 16);
        check(rd_data == exp_mem[row * 4 + k - 16], "R4 R5 word data",
              rd_data, exp_mem[row * 4 + k - 16]);
        check(done == (k == 19), "R6 done with last", done, (k == 19));
      end
    end
    @(negedge clk);
    check(req_ready && !rd_valid && !done, "R2 ready after read",
          {req_ready, rd_valid, done}, 3'b100);
  endtask

  task automatic read_all(input int salt);
    for (int r = 0; r < NWORD / 4; r++) begin
      do_read(r * 4 + ((r + salt) % 4), 1'b0, 1'b0, 1'b0, 0);  // R5 low bits vary
    end
  endtask

  task automatic run_main;
    // R1 during and after reset
    repeat (3) @(negedge clk);
    check(req_ready && !rd_valid && !done, "R1 in reset", {req_ready, rd_valid, done}, 3'b100);
    rst_ni = 1'b1;
    @(negedge clk);
    check(req_ready && !rd_valid && !done, "R1 after reset", {req_ready, rd_valid, done}, 3'b100);

    for (int a = 0; a < NWORD; a++) do_write(a, pattern(a, 0));  // R7
    read_all(0);
    read_all(1);

    do_write(37, 32'h0BAD_F00D);  // R8 single-word overwrite
    read_all(2);

    do_read(8, 1'b0, 1'b1, 1'b0, 0);  // R9 busy poke
    read_all(3);

    do_read(20, 1'b0, 1'b0, 1'b1, 27);  // R2 back-to-back
    do_read(27, 1'b1, 1'b0, 1'b0, 0);
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule